// File: doc/BRIEF.md
# Speculative load address table

This block guards loads that a compiler has moved above earlier stores. When such a load issues early, the insert port records the register it writes and the address it read. Every store that follows is compared against all recorded addresses. If a store hits a recorded word, that entry is marked as violated.

At the point where the load originally stood, a check operation names the same register. One cycle later the block answers with a verdict. The answer is "keep" when the entry is still present and clean. It is "reload" when the entry is violated, was evicted, or was never written. Each check consumes the entry it looked at.

The table holds `DEPTH` entries, and each register owns at most one of them. Addresses are compared at word granularity. When no slot is free, the entry inserted longest ago is replaced.

Top module: `ldchk_table`

## Requirements
- R1: An insert records the register and address. A later check of that register, with no matching store in between, answers keep (`chk_reload` = 0).
- R2: A store whose address agrees with a recorded address in every bit above bit 1 marks that entry violated, whatever the two low bits are (a word is 4 bytes). A later check answers reload (`chk_reload` = 1).
- R3: A store to a different word leaves every entry unchanged. A later check of an untouched entry answers keep.
- R4: A check of a register that has no entry answers reload.
- R5: An insert to a register that already has an entry replaces that entry. The old address is dropped, the violation mark is cleared, and the register never owns two entries.
- R6: An insert into a full table with no entry for its register evicts the entry whose last insert is oldest. Re-inserting a register counts as a fresh insert, and removing an entry by a check closes the gap in the age order. A check of the evicted register answers reload.
- R7: A check removes the entry it looked at, whatever its verdict. A second check of the same register answers reload.
- R8: When an insert and a matching store occur in the same cycle, the store is compared only with the old contents. The newly written entry is never marked violated by that store.
- R9: `chk_ack` is high in exactly the cycle after each cycle with `chk_valid`, and low otherwise. The verdict reflects the table as it stood before that clock edge, so a store in the same cycle as the check does not affect it.
- R10: When a check and an insert name the same register in one cycle, the check judges the old entry and the newly inserted entry survives.
- R11: Reset empties the table and clears `chk_ack`. After reset, every check answers reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Record an advanced load this cycle |
| ins_reg | input | REG_W | Destination register of the advanced load |
| ins_addr | input | ADDR_W | Byte address read by the advanced load |
| st_valid | input | 1 | A store is issuing this cycle |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_valid | input | 1 | Check request from the load's original position |
| chk_reg | input | REG_W | Register whose load is being checked |
| chk_ack | output | 1 | Verdict valid, one cycle after `chk_valid` |
| chk_reload | output | 1 | 1 = re-execute the load, 0 = keep the speculative value |

## Verification
The bench attacks four cases that are easy to get wrong:
- A store that hits the same word at a different byte offset. A design comparing full byte addresses would wrongly answer keep.
- Eviction after a re-insert, and eviction after a check has removed an entry. An age tracker that does not refresh on re-insert, or that leaves gaps, would evict the wrong register or let a rank overflow.
- Same-cycle collisions of a store or a check with an insert. A design letting the store win would report a spurious reload, and one letting the check win would lose the new entry.
- A second check of a consumed entry, and a check after a mid-run reset. A design that keeps consumed or pre-reset entries would answer keep where reload is due.

// File: rtl/ldchk_pkg.sv
package ldchk_pkg;

    typedef enum logic {
        VERDICT_KEEP   = 1'b0,
        VERDICT_RELOAD = 1'b1
    } verdict_e;

    // keep only when the entry exists and no store touched it
    function automatic verdict_e judge(input logic hit, input logic viol);
        return (hit && !viol) ? VERDICT_KEEP : VERDICT_RELOAD;
    endfunction

endpackage

// File: rtl/ldchk_slot.sv
module ldchk_slot #(
    parameter int REG_W   = 5,
    parameter int WADDR_W = 30,
    parameter int RANK_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_here,
    input  logic [REG_W-1:0]   ins_tag,
    input  logic [WADDR_W-1:0] ins_waddr,
    input  logic               inv_here,
    input  logic               bump,
    input  logic               shrink,
    input  logic               st_valid,
    input  logic [WADDR_W-1:0] st_waddr,
    output logic               valid_o,
    output logic [REG_W-1:0]   tag_o,
    output logic               viol_o,
    output logic [RANK_W-1:0]  rank_o
);

    logic [WADDR_W-1:0] waddr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            viol_o  <= 1'b0;
            rank_o  <= '0;
            waddr_q <= '0;
        end else if (ins_here) begin
            // insert wins over a same-cycle store or check (R8, R10)
            valid_o <= 1'b1;
            tag_o   <= ins_tag;
            waddr_q <= ins_waddr;
            viol_o  <= 1'b0;
            rank_o  <= '0;
        end else if (inv_here) begin
            valid_o <= 1'b0;
            viol_o  <= 1'b0;
        end else if (valid_o) begin
            if (st_valid && (st_waddr == waddr_q)) begin
                viol_o <= 1'b1;
            end
            rank_o <= rank_o + RANK_W'(bump) - RANK_W'(shrink);
        end
    end

endmodule

// File: rtl/ldchk_pick.sv
module ldchk_pick #(
    parameter int DEPTH  = 4,
    parameter int RANK_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [DEPTH-1:0]  valid_v,
    input  logic [DEPTH-1:0]  same_v,
    input  logic [RANK_W-1:0] rank_a [DEPTH],
    output logic [IDX_W-1:0]  tgt,
    output logic              tgt_valid,
    output logic [RANK_W-1:0] tgt_rank
);

    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(DEPTH - 1);

    // priority: own register's slot, then lowest free slot, then oldest
    always_comb begin
        logic found;
        found = 1'b0;
        tgt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && same_v[i]) begin
                tgt   = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && !valid_v[i]) begin
                tgt   = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && (rank_a[i] == OLDEST)) begin
                tgt   = IDX_W'(i);
                found = 1'b1;
            end
        end
        tgt_valid = valid_v[tgt];
        tgt_rank  = rank_a[tgt];
    end

endmodule

// File: rtl/ldchk_table.sv
module ldchk_table
    import ldchk_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int REG_W      = 5,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [REG_W-1:0]  ins_reg,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_ack,
    output logic              chk_reload
);

    localparam int WOFF    = $clog2(WORD_BYTES);
    localparam int WADDR_W = ADDR_W - WOFF;
    localparam int RANK_W  = $clog2(DEPTH);
    localparam int IDX_W   = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid_v, viol_v, ins_same, chk_hit_v, ins_here;
    logic [DEPTH-1:0]  inv_v, bump_v, shrink_v, oldest_v;
    logic [REG_W-1:0]  tag_a  [DEPTH];
    logic [RANK_W-1:0] rank_a [DEPTH];
    logic [IDX_W-1:0]  tgt;
    logic              tgt_valid;
    logic [RANK_W-1:0] tgt_rank, inv_rank;
    logic              inv_any, chk_hit, chk_viol;
    logic              ack_q;
    verdict_e          verdict_q;

    ldchk_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
        .valid_v  (valid_v),
        .same_v   (ins_same),
        .rank_a   (rank_a),
        .tgt      (tgt),
        .tgt_valid(tgt_valid),
        .tgt_rank (tgt_rank)
    );

    assign inv_any  = |inv_v;
    assign chk_hit  = |chk_hit_v;
    assign chk_viol = |(chk_hit_v & viol_v);

    always_comb begin
        inv_rank = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (inv_v[i]) inv_rank = rank_a[i];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign ins_same[i]  = valid_v[i] && (tag_a[i] == ins_reg);
        assign chk_hit_v[i] = valid_v[i] && (tag_a[i] == chk_reg);
        assign ins_here[i]  = ins_valid && (tgt == IDX_W'(i));
        assign inv_v[i]     = chk_valid && chk_hit_v[i] && !ins_here[i];
        // younger than the slot being (re)written: age by one (R6)
        assign bump_v[i]    = ins_valid && valid_v[i] && !ins_here[i] &&
                              (!tgt_valid || (rank_a[i] < tgt_rank));
        // older than the consumed entry: close the gap (R6, R7)
        assign shrink_v[i]  = inv_any && valid_v[i] && !inv_v[i] &&
                              (rank_a[i] > inv_rank);
        assign oldest_v[i]  = valid_v[i] && (rank_a[i] == RANK_W'(DEPTH - 1));

        ldchk_slot #(.REG_W(REG_W), .WADDR_W(WADDR_W), .RANK_W(RANK_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ins_here (ins_here[i]),
            .ins_tag  (ins_reg),
            .ins_waddr(ins_addr[ADDR_W-1:WOFF]),
            .inv_here (inv_v[i]),
            .bump     (bump_v[i]),
            .shrink   (shrink_v[i]),
            .st_valid (st_valid),
            .st_waddr (st_addr[ADDR_W-1:WOFF]),
            .valid_o  (valid_v[i]),
            .tag_o    (tag_a[i]),
            .viol_o   (viol_v[i]),
            .rank_o   (rank_a[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            verdict_q <= VERDICT_KEEP;
        end else begin
            ack_q     <= chk_valid;
            verdict_q <= chk_valid ? judge(chk_hit, chk_viol) : VERDICT_KEEP;
        end
    end

    assign chk_ack    = ack_q;
    assign chk_reload = (verdict_q == VERDICT_RELOAD);

    function automatic logic has_tag(input logic [REG_W-1:0] r);
        logic f;
        f = 1'b0;
        for (int i = 0; i < DEPTH; i++) f = f | (valid_v[i] && (tag_a[i] == r));
        return f;
    endfunction

    function automatic logic tag_viol(input logic [REG_W-1:0] r);
        logic f;
        f = 1'b0;
        for (int i = 0; i < DEPTH; i++) f = f | (valid_v[i] && viol_v[i] && (tag_a[i] == r));
        return f;
    endfunction

    assert_insert_recorded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> has_tag($past(ins_reg)));

    assert_one_entry_per_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> $onehot0(ins_same));

    assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_v) |-> ($countones(oldest_v) == 1));

    assert_miss_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_hit) |=> chk_reload);

    assert_check_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_hit && !(ins_valid && (ins_reg == chk_reg)))
        |=> !has_tag($past(chk_reg)));

    assert_insert_beats_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && st_valid) |=> !tag_viol($past(ins_reg)));

endmodule

// File: tb/sim_ldchk_table.sv
module sim_ldchk_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [4:0]  ins_reg = '0;
    logic [31:0] ins_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        chk_valid = 1'b0;
    logic [4:0]  chk_reg = '0;
    logic        chk_ack, chk_reload;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldchk_table u0 (.*);

    typedef struct packed {
        logic        iv;
        logic [4:0]  ir;
        logic [31:0] ia;
        logic        sv;
        logic [31:0] sa;
        logic        cv;
        logic [4:0]  cr;
        logic        er;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1'b1, 5'd1, 32'h100, 1'b0, 32'h0,   1'b0, 5'd0, 1'b0}, // R1 insert
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd1, 1'b0}, // R1 check keep
        '{1'b1, 5'd2, 32'h200, 1'b0, 32'h0,   1'b0, 5'd0, 1'b0}, // R2 insert
        '{1'b0, 5'd0, 32'h0,   1'b1, 32'h203, 1'b0, 5'd0, 1'b0}, // R2 store same word
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd2, 1'b1}, // R2 check reload
        '{1'b1, 5'd3, 32'h300, 1'b0, 32'h0,   1'b0, 5'd0, 1'b0}, // R3 insert
        '{1'b0, 5'd0, 32'h0,   1'b1, 32'h304, 1'b0, 5'd0, 1'b0}, // R3 next word
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd3, 1'b0}, // R3 check keep
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd4, 1'b1}, // R4 never inserted
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd1, 1'b1}, // R7 consumed
        '{1'b1, 5'd5, 32'h500, 1'b0, 32'h0,   1'b0, 5'd0, 1'b0}, // R5 insert
        '{1'b0, 5'd0, 32'h0,   1'b1, 32'h500, 1'b0, 5'd0, 1'b0}, // R5 violate
        '{1'b1, 5'd5, 32'h600, 1'b0, 32'h0,   1'b0, 5'd0, 1'b0}, // R5 overwrite
        '{1'b0, 5'd0, 32'h0,   1'b1, 32'h500, 1'b0, 5'd0, 1'b0}, // R5 old address
        '{1'b0, 5'd0, 32'h0,   1'b0, 32'h0,   1'b1, 5'd5, 1'b0}  // R5 check keep
    };

    task automatic op(input logic iv, input logic [4:0] ir, input logic [31:0] ia,
                      input logic sv, input logic [31:0] sa,
                      input logic cv, input logic [4:0] cr);
        @(negedge clk);
        ins_valid = iv; ins_reg = ir; ins_addr = ia;
        st_valid = sv;  st_addr = sa;
        chk_valid = cv; chk_reg = cr;
        @(posedge clk);
        #1;
        ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic ack_e, input logic rl_e);
        n_cmp++;
        if (chk_ack !== ack_e || (ack_e && chk_reload !== rl_e)) begin
            n_bad++;
            $display("FAIL %s: ack/reload = %b/%b, expected %b/%b",
                     req, chk_ack, chk_reload, ack_e, rl_e);
        end
    endtask

    task automatic ins(input logic [4:0] r, input logic [31:0] a);
        op(1'b1, r, a, 1'b0, 32'h0, 1'b0, 5'd0);
    endtask

    task automatic chk(input string req, input logic [4:0] r, input logic rl_e);
        op(1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 1'b1, r);
        expect_out(req, 1'b1, rl_e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_out("R11 ack low in reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 empty after reset", 5'd0, 1'b1);

        // vector table
        for (int k = 0; k < NV; k++) begin
            op(VT[k].iv, VT[k].ir, VT[k].ia, VT[k].sv, VT[k].sa, VT[k].cv, VT[k].cr);
            expect_out($sformatf("vector %0d (R9 ack)", k), VT[k].cv, VT[k].er);
        end

        // R6: re-insert refreshes age, so r11 is the oldest when r14 arrives
        ins(5'd10, 32'h1000);
        ins(5'd11, 32'h1100);
        ins(5'd12, 32'h1200);
        ins(5'd13, 32'h1300);
        ins(5'd10, 32'h1010);
        ins(5'd14, 32'h1400);
        chk("R6 oldest evicted", 5'd11, 1'b1);
        chk("R6 refreshed kept", 5'd10, 1'b0);
        chk("R6 kept r12", 5'd12, 1'b0);
        chk("R6 kept r13", 5'd13, 1'b0);
        chk("R6 newest kept", 5'd14, 1'b0);

        // R6 with a gap closed by a check
        ins(5'd1, 32'h40);
        ins(5'd2, 32'h44);
        chk("R7 consume r1", 5'd1, 1'b0);
        ins(5'd3, 32'h48);
        ins(5'd4, 32'h4c);
        ins(5'd5, 32'h50);
        ins(5'd6, 32'h54);
        chk("R6 gap: r2 evicted", 5'd2, 1'b1);
        chk("R6 gap: r3 kept", 5'd3, 1'b0);
        chk("R6 gap: r6 kept", 5'd6, 1'b0);
        chk("R7 second check of r1", 5'd1, 1'b1);

        // R8: store and insert collide
        ins(5'd7, 32'h700);
        op(1'b1, 5'd7, 32'h700, 1'b1, 32'h702, 1'b0, 5'd0);
        expect_out("R8 no ack", 1'b0, 1'b0);
        chk("R8 overwrite wins", 5'd7, 1'b0);
        op(1'b1, 5'd8, 32'h800, 1'b1, 32'h800, 1'b0, 5'd0);
        chk("R8 fresh insert wins", 5'd8, 1'b0);

        // R9: store in same cycle as check
        ins(5'd9, 32'h900);
        op(1'b0, 5'd0, 32'h0, 1'b1, 32'h900, 1'b1, 5'd9);
        expect_out("R9 store same cycle as check", 1'b1, 1'b0);

        // R10: check and insert same register
        ins(5'd9, 32'h900);
        op(1'b0, 5'd0, 32'h0, 1'b1, 32'h901, 1'b0, 5'd0);
        op(1'b1, 5'd9, 32'hA00, 1'b0, 32'h0, 1'b1, 5'd9);
        expect_out("R10 old entry judged", 1'b1, 1'b1);
        chk("R10 new entry survives", 5'd9, 1'b0);

        // R11: mid-run reset empties table
        ins(5'd3, 32'h30);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        expect_out("R11 ack cleared", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 entry gone after reset", 5'd3, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule